// File: doc/BRIEF.md
# Wishbone 32-to-8 Width Downsizer

This bridge lets a master with a 32-bit Wishbone data bus reach a slave whose data bus is 8 bits wide, for example a register file of byte-wide peripheral registers. The master always presents a word-aligned address and marks the byte it wants with a one-hot byte select. The bridge turns that select into the two low address bits of a byte address for the narrow slave. It steers the chosen write byte down onto the 8-bit bus. It places the returned read byte back on the same lane of the 32-bit read bus.

The numbering of byte lanes against byte offsets is fixed at compile time by an endianness parameter. This allows a single design to serve both little-endian and big-endian masters, including access to registers that sit at byte offsets other than zero. Cycle, write enable and acknowledge pass through without registers, so a single classic cycle takes exactly as long as the slave needs. A select that does not mark exactly one lane never reaches the slave. It is answered with a one-cycle error acknowledge instead.

Top module: `wbd_downsizer`

## Requirements
- R1: With little-endian numbering, select bit k (bit 0 = data bits 7:0) drives slave address bits [1:0] to k.
- R2: With big-endian numbering, select bit k drives slave address bits [1:0] to 3-k, so select 1000 reaches offset 0 and 0001 reaches offset 3.
- R3: During a write with select bit k set, the slave write byte equals master write data bits [8k+7:8k].
- R4: When a valid access is acknowledged, master read data lane k (bits [8k+7:8k]) carries the slave read byte, and every other lane reads zero.
- R5: The slave cycle and write enable follow the master's without delay. The slave strobe follows the master strobe, and the master acknowledge follows the slave acknowledge, whenever the select is one-hot. A valid access is acknowledged at the first clock edge at which a one-cycle slave answers.
- R6: A request (cycle and strobe high) whose select is zero or has several bits set leaves the slave strobe low and the master acknowledge low. It raises the master error output for exactly one cycle, starting at the next clock edge. No slave register changes.
- R7: While reset is asserted, the error output is low.
- R8: Slave address bits [31:2] equal master address bits [31:2]. Master address bits [1:0] have no effect on the slave address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_adr_i | input | 32 | Master address, word aligned |
| m_dat_i | input | 32 | Master write data |
| m_sel_i | input | 4 | Master byte select, one-hot expected |
| m_we_i | input | 1 | Master write enable |
| m_cyc_i | input | 1 | Master bus cycle |
| m_stb_i | input | 1 | Master strobe |
| m_dat_o | output | 32 | Read data toward the master |
| m_ack_o | output | 1 | Acknowledge toward the master |
| m_err_o | output | 1 | Error acknowledge for an unsupported select |
| s_adr_o | output | 32 | Byte address toward the slave |
| s_dat_o | output | 8 | Write byte toward the slave |
| s_we_o | output | 1 | Slave write enable |
| s_cyc_o | output | 1 | Slave bus cycle |
| s_stb_o | output | 1 | Slave strobe |
| s_dat_i | input | 8 | Read byte from the slave |
| s_ack_i | input | 1 | Acknowledge from the slave |

## Verification
Almost all of the bridge is combinational. A wrong lane-to-offset decode therefore shows up in the same cycle as a wrong slave address or a wrong write byte. After that, it remains in the narrow register file, where a later read-back from a different offset exposes it. The only state is the error flag. If that flag sticks high or fails to clear, the error output will be wrong on the edge right after an unsupported select. This is checked for each endianness on a separate instance, and both instances run against reference register files kept in the bench.

// File: rtl/wbd_pkg.sv
package wbd_pkg;
  typedef enum logic {
    ENDIAN_LITTLE = 1'b0,
    ENDIAN_BIG    = 1'b1
  } endian_e;
endpackage

// File: rtl/wbd_sel_decode.sv
module wbd_sel_decode
  import wbd_pkg::*;
#(
  parameter int      LANES  = 4,
  parameter int      OFF_W  = 2,
  parameter endian_e ENDIAN = ENDIAN_LITTLE
) (
  input  logic [LANES-1:0] sel_i,
  output logic [OFF_W-1:0] off_o,
  output logic             one_hot_o
);
  logic [LANES-1:0] sel_ord;

  // lane order reversal is the only difference between the two numberings
  generate
    if (ENDIAN == ENDIAN_BIG) begin : g_big
      for (genvar k = 0; k < LANES; k++) begin : g_rev
        assign sel_ord[k] = sel_i[LANES-1-k];
      end
    end else begin : g_little
      assign sel_ord = sel_i;
    end
  endgenerate

  always_comb begin
    off_o = '0;
    for (int k = 0; k < LANES; k++) begin
      if (sel_ord[k]) off_o = off_o | OFF_W'(k);
    end
  end

  assign one_hot_o = (sel_i != '0) && ((sel_i & (sel_i - LANES'(1))) == '0);
endmodule

// File: rtl/wbd_wr_lane.sv
module wbd_wr_lane #(
  parameter int LANES    = 4,
  parameter int NARROW_W = 8,
  localparam int WIDE_W  = LANES * NARROW_W
) (
  input  logic [LANES-1:0]    sel_i,
  input  logic [WIDE_W-1:0]   wide_i,
  output logic [NARROW_W-1:0] narrow_o
);
  always_comb begin
    narrow_o = '0;
    for (int k = 0; k < LANES; k++) begin
      if (sel_i[k]) narrow_o = narrow_o | wide_i[k*NARROW_W +: NARROW_W];
    end
  end
endmodule

// File: rtl/wbd_rd_lane.sv
module wbd_rd_lane #(
  parameter int LANES    = 4,
  parameter int NARROW_W = 8,
  localparam int WIDE_W  = LANES * NARROW_W
) (
  input  logic [LANES-1:0]    sel_i,
  input  logic [NARROW_W-1:0] narrow_i,
  output logic [WIDE_W-1:0]   wide_o
);
  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign wide_o[k*NARROW_W +: NARROW_W] = sel_i[k] ? narrow_i : '0;
    end
  endgenerate
endmodule

// File: rtl/wbd_err_resp.sv
module wbd_err_resp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic sel_ok_i,
  output logic err_o
);
  logic err_q;

  // one-cycle pulse; master is expected to drop stb after it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= req_i & ~sel_ok_i & ~err_q;
  end

  assign err_o = err_q;
endmodule

// File: rtl/wbd_downsizer.sv
module wbd_downsizer
  import wbd_pkg::*;
#(
  parameter int      ADDR_W   = 32,
  parameter int      WIDE_W   = 32,
  parameter int      NARROW_W = 8,
  parameter endian_e ENDIAN   = ENDIAN_LITTLE,
  localparam int     LANES    = WIDE_W / NARROW_W,
  localparam int     OFF_W    = $clog2(LANES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   m_adr_i,
  input  logic [WIDE_W-1:0]   m_dat_i,
  input  logic [LANES-1:0]    m_sel_i,
  input  logic                m_we_i,
  input  logic                m_cyc_i,
  input  logic                m_stb_i,
  output logic [WIDE_W-1:0]   m_dat_o,
  output logic                m_ack_o,
  output logic                m_err_o,
  output logic [ADDR_W-1:0]   s_adr_o,
  output logic [NARROW_W-1:0] s_dat_o,
  output logic                s_we_o,
  output logic                s_cyc_o,
  output logic                s_stb_o,
  input  logic [NARROW_W-1:0] s_dat_i,
  input  logic                s_ack_i
);
  logic [OFF_W-1:0] off;
  logic             sel_ok;
  logic             unused_adr_lo;

  assign unused_adr_lo = ^m_adr_i[OFF_W-1:0];

  wbd_sel_decode #(
    .LANES (LANES),
    .OFF_W (OFF_W),
    .ENDIAN(ENDIAN)
  ) i_sel_decode (
    .sel_i    (m_sel_i),
    .off_o    (off),
    .one_hot_o(sel_ok)
  );

  wbd_wr_lane #(
    .LANES   (LANES),
    .NARROW_W(NARROW_W)
  ) i_wr_lane (
    .sel_i   (m_sel_i),
    .wide_i  (m_dat_i),
    .narrow_o(s_dat_o)
  );

  wbd_rd_lane #(
    .LANES   (LANES),
    .NARROW_W(NARROW_W)
  ) i_rd_lane (
    .sel_i   (m_sel_i),
    .narrow_i(s_dat_i),
    .wide_o  (m_dat_o)
  );

  wbd_err_resp i_err_resp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (m_cyc_i & m_stb_i),
    .sel_ok_i(sel_ok),
    .err_o   (m_err_o)
  );

  assign s_adr_o = {m_adr_i[ADDR_W-1:OFF_W], off};
  assign s_cyc_o = m_cyc_i;
  assign s_we_o  = m_we_i;
  assign s_stb_o = m_stb_i & sel_ok;
  assign m_ack_o = s_ack_i & sel_ok;
endmodule

// File: rtl/wbd_downsizer_chk.sv
module wbd_downsizer_chk
  import wbd_pkg::*;
#(
  parameter int      ADDR_W   = 32,
  parameter int      WIDE_W   = 32,
  parameter int      NARROW_W = 8,
  parameter endian_e ENDIAN   = ENDIAN_LITTLE,
  localparam int     LANES    = WIDE_W / NARROW_W,
  localparam int     OFF_W    = $clog2(LANES)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   m_adr_i,
  input logic [WIDE_W-1:0]   m_dat_i,
  input logic [LANES-1:0]    m_sel_i,
  input logic                m_we_i,
  input logic                m_cyc_i,
  input logic                m_stb_i,
  input logic [WIDE_W-1:0]   m_dat_o,
  input logic                m_ack_o,
  input logic                m_err_o,
  input logic [ADDR_W-1:0]   s_adr_o,
  input logic [NARROW_W-1:0] s_dat_o,
  input logic                s_we_o,
  input logic                s_cyc_o,
  input logic                s_stb_o,
  input logic [NARROW_W-1:0] s_dat_i,
  input logic                s_ack_i
);
  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      if (ENDIAN == ENDIAN_LITTLE) begin : g_le
        assert_le_offset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (s_stb_o && m_sel_i[k]) |-> s_adr_o[OFF_W-1:0] == OFF_W'(k));
      end else begin : g_be
        assert_be_offset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (s_stb_o && m_sel_i[k]) |-> s_adr_o[OFF_W-1:0] == OFF_W'(LANES-1-k));
      end

      assert_wr_lane_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_stb_o && m_we_i && m_sel_i[k]) |-> s_dat_o == m_dat_i[k*NARROW_W +: NARROW_W]);

      assert_rd_lane_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m_ack_o && m_sel_i[k]) |-> m_dat_o == (WIDE_W'(s_dat_i) << (k*NARROW_W)));
    end
  endgenerate

  assert_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_cyc_o == m_cyc_i) && (s_we_o == m_we_i));

  assert_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_ack_i && $onehot(m_sel_i)) |-> m_ack_o);

  assert_block_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_cyc_i && m_stb_i && !$onehot(m_sel_i)) |-> (!s_stb_o && !m_ack_o));

  assert_err_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_cyc_i && m_stb_i && !$onehot(m_sel_i) && !m_err_o) |=> m_err_o);

  assert_err_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_err_o |=> !m_err_o);

  assert_reset_R7: assert property (@(posedge clk_i) !rst_ni |-> !m_err_o);

  assert_upper_adr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_stb_o |-> s_adr_o[ADDR_W-1:OFF_W] == m_adr_i[ADDR_W-1:OFF_W]);
endmodule

bind wbd_downsizer wbd_downsizer_chk #(
  .ADDR_W  (ADDR_W),
  .WIDE_W  (WIDE_W),
  .NARROW_W(NARROW_W),
  .ENDIAN  (ENDIAN)
) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .m_adr_i(m_adr_i),
  .m_dat_i(m_dat_i),
  .m_sel_i(m_sel_i),
  .m_we_i (m_we_i),
  .m_cyc_i(m_cyc_i),
  .m_stb_i(m_stb_i),
  .m_dat_o(m_dat_o),
  .m_ack_o(m_ack_o),
  .m_err_o(m_err_o),
  .s_adr_o(s_adr_o),
  .s_dat_o(s_dat_o),
  .s_we_o (s_we_o),
  .s_cyc_o(s_cyc_o),
  .s_stb_o(s_stb_o),
  .s_dat_i(s_dat_i),
  .s_ack_i(s_ack_i)
);

// File: tb/tb_byte_slave.sv
module tb_byte_slave #(
  parameter int DEPTH_W = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cyc_i,
  input  logic        stb_i,
  input  logic        we_i,
  input  logic [31:0] adr_i,
  input  logic [7:0]  dat_i,
  output logic [7:0]  dat_o,
  output logic        ack_o
);
  logic [7:0] mem [2**DEPTH_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o <= 1'b0;
      dat_o <= 8'h00;
      for (int i = 0; i < 2**DEPTH_W; i++) mem[i] <= 8'(8'hA0 + i);
    end else begin
      ack_o <= cyc_i & stb_i & ~ack_o;
      if (cyc_i && stb_i && !ack_o) begin
        dat_o <= mem[adr_i[DEPTH_W-1:0]];
        if (we_i) mem[adr_i[DEPTH_W-1:0]] <= dat_i;
      end
    end
  end
endmodule

// File: tb/test_wbd_downsizer.sv
module test_wbd_downsizer;
  import wbd_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] m_adr, m_dat;
  logic [3:0]  m_sel;
  logic        m_we, m_cyc, m_stb;

  logic [31:0] le_m_dat, be_m_dat, le_s_adr, be_s_adr;
  logic        le_ack, be_ack, le_err, be_err;
  logic [7:0]  le_s_dat, be_s_dat, le_s_rd, be_s_rd;
  logic        le_s_we, be_s_we, le_s_cyc, be_s_cyc, le_s_stb, be_s_stb;
  logic        le_s_ack, be_s_ack;

  logic [7:0] ref_le [16];
  logic [7:0] ref_be [16];
  int n_checks = 0;
  int n_err    = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  wbd_downsizer #(.ENDIAN(ENDIAN_LITTLE)) i_wbd_downsizer (
    .clk_i(clk), .rst_ni(rst_n),
    .m_adr_i(m_adr), .m_dat_i(m_dat), .m_sel_i(m_sel), .m_we_i(m_we),
    .m_cyc_i(m_cyc), .m_stb_i(m_stb),
    .m_dat_o(le_m_dat), .m_ack_o(le_ack), .m_err_o(le_err),
    .s_adr_o(le_s_adr), .s_dat_o(le_s_dat), .s_we_o(le_s_we),
    .s_cyc_o(le_s_cyc), .s_stb_o(le_s_stb),
    .s_dat_i(le_s_rd), .s_ack_i(le_s_ack)
  );

  wbd_downsizer #(.ENDIAN(ENDIAN_BIG)) i_wbd_downsizer_be (
    .clk_i(clk), .rst_ni(rst_n),
    .m_adr_i(m_adr), .m_dat_i(m_dat), .m_sel_i(m_sel), .m_we_i(m_we),
    .m_cyc_i(m_cyc), .m_stb_i(m_stb),
    .m_dat_o(be_m_dat), .m_ack_o(be_ack), .m_err_o(be_err),
    .s_adr_o(be_s_adr), .s_dat_o(be_s_dat), .s_we_o(be_s_we),
    .s_cyc_o(be_s_cyc), .s_stb_o(be_s_stb),
    .s_dat_i(be_s_rd), .s_ack_i(be_s_ack)
  );

  tb_byte_slave i_slave_le (
    .clk_i(clk), .rst_ni(rst_n), .cyc_i(le_s_cyc), .stb_i(le_s_stb),
    .we_i(le_s_we), .adr_i(le_s_adr), .dat_i(le_s_dat),
    .dat_o(le_s_rd), .ack_o(le_s_ack)
  );

  tb_byte_slave i_slave_be (
    .clk_i(clk), .rst_ni(rst_n), .cyc_i(be_s_cyc), .stb_i(be_s_stb),
    .we_i(be_s_we), .adr_i(be_s_adr), .dat_i(be_s_dat),
    .dat_o(be_s_rd), .ack_o(be_s_ack)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  endtask

  // one single classic cycle, checked against the reference register files
  task automatic xfer(input logic [31:0] adr, input logic [3:0] sel, input logic we,
                      input logic [31:0] wdat);
    bit ok = ($countones(sel) == 1);
    int k = 0;
    int ile, ibe, n;
    for (int i = 3; i >= 0; i--) if (sel[i]) k = i;
    ile = int'(adr[3:2]) * 4 + k;
    ibe = int'(adr[3:2]) * 4 + (3 - k);

    @(negedge clk);
    m_adr = adr; m_sel = sel; m_we = we; m_dat = wdat;
    m_cyc = 1'b1; m_stb = 1'b1;
    #1;
    chk(le_s_cyc && be_s_cyc && le_s_we == we && be_s_we == we, "R5 cyc/we pass",
        {le_s_cyc, be_s_cyc, le_s_we, be_s_we}, {1'b1, 1'b1, we, we});
    if (ok) begin
      chk(le_s_stb && be_s_stb, "R5 strobe", {le_s_stb, be_s_stb}, 2'b11);
      chk(le_s_adr == {adr[31:2], 2'(k)}, "R1 LE address + R8", le_s_adr, {adr[31:2], 2'(k)});
      chk(be_s_adr == {adr[31:2], 2'(3 - k)}, "R2 BE address + R8", be_s_adr, {adr[31:2], 2'(3 - k)});
      if (we) begin
        chk(le_s_dat == wdat[8*k +: 8], "R3 LE write byte", le_s_dat, wdat[8*k +: 8]);
        chk(be_s_dat == wdat[8*k +: 8], "R3 BE write byte", be_s_dat, wdat[8*k +: 8]);
      end
    end else begin
      chk(!le_s_stb && !be_s_stb, "R6 slave not strobed", {le_s_stb, be_s_stb}, 0);
    end

    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(le_ack || le_err) && n < 10);
    if (n >= 10) chk(1'b0, "watchdog on transfer", n, 1);
    chk(n == 1, "R5/R6 response cycle", n, 1);

    if (ok) begin
      chk(le_ack && be_ack && !le_err && !be_err, "R5 ack",
          {le_ack, be_ack, le_err, be_err}, 4'b1100);
      if (!we) begin
        chk(le_m_dat == (32'(ref_le[ile]) << (8*k)), "R4 LE read lane", le_m_dat,
            32'(ref_le[ile]) << (8*k));
        chk(be_m_dat == (32'(ref_be[ibe]) << (8*k)), "R4 BE read lane", be_m_dat,
            32'(ref_be[ibe]) << (8*k));
      end else begin
        ref_le[ile] = wdat[8*k +: 8];
        ref_be[ibe] = wdat[8*k +: 8];
      end
    end else begin
      chk(le_err && be_err && !le_ack && !be_ack, "R6 error ack",
          {le_err, be_err, le_ack, be_ack}, 4'b1100);
    end

    m_cyc = 1'b0; m_stb = 1'b0; m_we = 1'b0;
    @(negedge clk);
    chk(!le_err && !be_err, "R6 error one cycle", {le_err, be_err}, 0);
    chk(!le_s_stb && !be_s_stb, "R5 strobe idle", {le_s_stb, be_s_stb}, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_adr = '0; m_dat = '0; m_sel = '0; m_we = 1'b0; m_cyc = 1'b0; m_stb = 1'b0;
    for (int i = 0; i < 16; i++) begin
      ref_le[i] = 8'(8'hA0 + i);
      ref_be[i] = 8'(8'hA0 + i);
    end
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!le_err && !be_err && !le_ack && !be_ack, "R7 reset state",
        {le_err, be_err, le_ack, be_ack}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // reset content through several offsets, address low bits set (R8)
    xfer(32'h0000_1003, 4'b0001, 1'b0, 32'h0);
    xfer(32'h0000_1006, 4'b1000, 1'b0, 32'h0);

    // every lane of every word, low address bits varying (R1, R2, R3, R8)
    for (int w = 0; w < 4; w++) begin
      for (int k = 0; k < 4; k++) begin
        xfer(32'h0000_3000 | 32'(w << 2) | 32'(w), 4'(1 << k), 1'b1,
             32'h1122_3344 ^ (32'(k) * 32'h0101_0101) ^ 32'(w * 32'h0F0F_0000));
      end
    end

    // unsupported selects: no slave write, error instead (R6)
    xfer(32'h0000_3000, 4'b0000, 1'b1, 32'hDEAD_BEEF);
    xfer(32'h0000_3004, 4'b0011, 1'b1, 32'hDEAD_BEEF);
    xfer(32'h0000_3008, 4'b1111, 1'b1, 32'hDEAD_BEEF);
    xfer(32'h0000_300C, 4'b1010, 1'b0, 32'h0);

    // read back all sixteen registers through both numberings (R4)
    for (int w = 0; w < 4; w++) begin
      for (int k = 0; k < 4; k++) begin
        xfer(32'hABCD_0001 | 32'(w << 2), 4'(1 << k), 1'b0, 32'h0);
      end
    end

    // single-byte overwrite then read at a non-zero offset
    xfer(32'h0000_0008, 4'b0100, 1'b1, 32'h00_5A_00_00);
    xfer(32'h0000_000B, 4'b0100, 1'b0, 32'h0);

    finish_run();
  end
endmodule